// File: doc/BRIEF.md
# Redundant-Channel Averaging Decimator

This block sits behind a multiplexed ADC that delivers 16 channels of 18-bit signed samples, one channel per valid cycle, at a per-channel rate of 524288 Hz. Four distinct signals are each wired to four ADC channels, so incoherent converter noise can be reduced by combining the copies. Copies of one signal sit at channel indices that agree modulo 4. For each signal the block adds the four copies into a 20-bit sum and divides it by four to return to single-channel units.

The raw 20-bit sum also feeds a per-signal window tracker that records the smallest and largest sum since the last clear and flags a sum that reaches converter full scale. The averaged stream is reduced in rate twice. A boxcar pre-filter and decimator by 8 produces a 65536 Hz rate. A second boxcar by 4 produces 16384 Hz. The result leaves on a valid/signal-id/data output, one beat per signal every 32 input frames.

Top module: `avg_decim_front`

## Requirements
- R1: A frame is 16 valid samples. The sample with `smp_sof` high is channel 0, and each following valid sample takes the next channel index. Signal g (0..3) is formed from channels g, g+4, g+8 and g+12.
- R2: The sum of four copies is held in 20 signed bits without overflow. Four samples of +131071 give +524284, and four samples of -131072 give -524288.
- R3: The average of a signal is its sum shifted arithmetically right by 2, which is floor(sum/4).
- R4: The first stage collects 8 consecutive averages of a signal and produces floor(total/8). The second stage collects 4 consecutive first-stage values of that signal and emits floor(total/4) on `out_data`.
- R5: `out_valid` pulses exactly once per signal for every 32 complete frames. `out_sig` carries the signal number, and the four signals leave in ascending order 0, 1, 2, 3.
- R6: `win_min` and `win_max` hold, in 20-bit fields at bit g*20 for signal g, the minimum and maximum raw sum seen since the last reload.
- R7: After a `win_clear` pulse, the next sum of each signal loads both its minimum and its maximum. A sum that arrives in the same cycle as the pulse counts as that next sum.
- R8: Bit g of `win_sat` is high while the maximum of signal g is at least +524284 or its minimum is at most -524288, and low otherwise.
- R9: During and after reset, `out_valid` is low, all window fields are zero, `win_sat` is zero, and every signal is set to reload on its first sum.
- R10: Cycles with `smp_valid` low change nothing, so idle gaps between samples do not alter any result.
- R11: A new `smp_sof` restarts the channel count at 0. A frame cut off before channel 12 produces no sums and leaves the following frame unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Input sample present this cycle |
| smp_sof | input | 1 | Marks channel 0 of a frame |
| smp_data | input | 18 | Signed ADC sample |
| win_clear | input | 1 | Pulse that makes each signal's next sum reload its window |
| out_valid | output | 1 | Decimated sample present |
| out_sig | output | 2 | Signal number of the decimated sample |
| out_data | output | 18 | Signed decimated average |
| win_min | output | 80 | Four 20-bit signed per-signal minima of the raw sum |
| win_max | output | 80 | Four 20-bit signed per-signal maxima of the raw sum |
| win_sat | output | 4 | Per-signal full-scale flag |

## Verification
A window clear and a sum update can land in the same cycle, and the design must then treat that sum as the reload value. The bench provokes this by raising `win_clear` together with channel 13 of a frame that is sent without gaps, which is the cycle in which signal 0's sum reaches the tracker. It judges the outcome by comparing all four windows, read through the output ports, with a model in which that frame reloads every signal. Cleared windows are also checked after directed full-scale frames, and the decimated output is compared beat by beat against a bench model fed with random frames that contain random gaps and one truncated frame.

// File: rtl/avg_decim_pkg.sv
// Shared defaults for the redundant-channel averaging decimator.
// Assumes signal count and copy count are powers of two.
package avg_decim_pkg;
    localparam int DEF_SMP_W = 18;   // ADC sample width
    localparam int DEF_NSIG  = 4;    // distinct signals per frame
    localparam int DEF_NCOPY = 4;    // copies of each signal
    localparam int DEF_DEC1  = 8;    // first decimation factor
    localparam int DEF_DEC2  = 4;    // second decimation factor
endpackage

// File: rtl/copy_combiner.sv
// Adds the NCOPY copies of each signal in a frame. Channel index c maps to
// signal c mod NSIG and copy c / NSIG. A registered sum leaves one cycle
// after the last copy is taken. Assumes NSIG and NCOPY are powers of two.
module copy_combiner #(
    parameter int SMP_W = 18,
    parameter int NSIG  = 4,
    parameter int NCOPY = 4,
    localparam int CH_W   = $clog2(NSIG * NCOPY),
    localparam int SIG_W  = $clog2(NSIG),
    localparam int COPY_W = CH_W - SIG_W,
    localparam int SUM_W  = SMP_W + $clog2(NCOPY)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic signed [SMP_W-1:0] in_data,
    output logic                    sum_valid,
    output logic [SIG_W-1:0]        sum_sig,
    output logic signed [SUM_W-1:0] sum_data
);
    logic [CH_W-1:0]         ch_q;
    logic [CH_W-1:0]         cur_ch;
    logic [SIG_W-1:0]        cur_sig;
    logic [COPY_W-1:0]       cur_copy;
    logic signed [SUM_W-1:0] ext;
    logic signed [SUM_W-1:0] nxt;
    logic signed [SUM_W-1:0] acc [NSIG];

    // Decode the channel of the present sample and form the running sum.
    always_comb begin
        cur_ch   = in_sof ? '0 : ch_q;
        cur_sig  = cur_ch[SIG_W-1:0];
        cur_copy = cur_ch[CH_W-1:SIG_W];
        ext      = SUM_W'(in_data);
        nxt      = (cur_copy == '0) ? ext : acc[cur_sig] + ext;
    end

    // Advance the channel count, accumulate copies, emit on the last copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q      <= '0;
            sum_valid <= 1'b0;
            sum_sig   <= '0;
            sum_data  <= '0;
            for (int i = 0; i < NSIG; i++) acc[i] <= '0;
        end else begin
            sum_valid <= 1'b0;
            if (in_valid) begin
                ch_q         <= cur_ch + 1'b1;
                acc[cur_sig] <= nxt;
                if (cur_copy == COPY_W'(NCOPY - 1)) begin
                    sum_valid <= 1'b1;
                    sum_sig   <= cur_sig;
                    sum_data  <= nxt;
                end
            end
        end
    end

    localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'(NCOPY * ((1 << (SMP_W - 1)) - 1));
    localparam logic signed [SUM_W-1:0] SUM_LO = SUM_W'(-(NCOPY * (1 << (SMP_W - 1))));

    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> (sum_data <= SUM_HI && sum_data >= SUM_LO)); // R2

    AST_SUM_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> $past(in_valid)); // R10
endmodule

// File: rtl/window_tracker.sv
// Keeps the running minimum and maximum of each signal's raw sum and a
// full-scale flag. A clear marks every signal to reload from its next sum;
// a sum arriving with the clear is that next sum.
module window_tracker #(
    parameter int SMP_W = 18,
    parameter int NSIG  = 4,
    parameter int NCOPY = 4,
    localparam int SIG_W = $clog2(NSIG),
    localparam int W     = SMP_W + $clog2(NCOPY)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sum_valid,
    input  logic [SIG_W-1:0]    sum_sig,
    input  logic signed [W-1:0] sum_data,
    input  logic                clear,
    output logic [NSIG*W-1:0]   min_flat,
    output logic [NSIG*W-1:0]   max_flat,
    output logic [NSIG-1:0]     sat
);
    localparam logic signed [W-1:0] POS_FS = W'(NCOPY * ((1 << (SMP_W - 1)) - 1));
    localparam logic signed [W-1:0] NEG_FS = W'(-(NCOPY * (1 << (SMP_W - 1))));

    logic signed [W-1:0] mn [NSIG];
    logic signed [W-1:0] mx [NSIG];
    logic [NSIG-1:0]     reload;

    // Update the window of the arriving signal; arm reloads on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '1;
            for (int i = 0; i < NSIG; i++) begin
                mn[i] <= '0;
                mx[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSIG; i++) begin
                if (sum_valid && sum_sig == SIG_W'(i)) begin
                    reload[i] <= 1'b0;
                    if (reload[i] || clear) begin
                        mn[i] <= sum_data;
                        mx[i] <= sum_data;
                    end else begin
                        if (sum_data < mn[i]) mn[i] <= sum_data;
                        if (sum_data > mx[i]) mx[i] <= sum_data;
                    end
                end else if (clear) begin
                    reload[i] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NSIG; g++) begin : g_out
        // Flatten the window and raise the flag at either full-scale end.
        assign min_flat[g*W +: W] = mn[g];
        assign max_flat[g*W +: W] = mx[g];
        assign sat[g] = (mx[g] >= POS_FS) || (mn[g] <= NEG_FS);

        AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            mn[g] <= mx[g]); // R6
    end
endmodule

// File: rtl/boxcar_decim.sv
// Boxcar pre-filter and decimator shared by all signals of a serial lane.
// For each signal it sums FACTOR inputs at full precision and emits the
// sum shifted right by log2(FACTOR), that is, floor of the mean.
// Assumes FACTOR is a power of two of at least 2.
module boxcar_decim #(
    parameter int NSIG   = 4,
    parameter int FACTOR = 8,
    parameter int W      = 18,
    localparam int LOGF  = $clog2(FACTOR),
    localparam int AW    = W + LOGF,
    localparam int SIG_W = $clog2(NSIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SIG_W-1:0]    in_sig,
    input  logic signed [W-1:0] in_data,
    output logic                out_valid,
    output logic [SIG_W-1:0]    out_sig,
    output logic signed [W-1:0] out_data
);
    logic signed [AW-1:0] acc [NSIG];
    logic [LOGF-1:0]      cnt [NSIG];
    logic signed [AW-1:0] total;

    // Running total including the present input.
    always_comb total = acc[in_sig] + AW'(in_data);

    // Accumulate per signal; on the last input emit the mean and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sig   <= '0;
            out_data  <= '0;
            for (int i = 0; i < NSIG; i++) begin
                acc[i] <= '0;
                cnt[i] <= '0;
            end
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                if (cnt[in_sig] == LOGF'(FACTOR - 1)) begin
                    acc[in_sig] <= '0;
                    cnt[in_sig] <= '0;
                    out_valid   <= 1'b1;
                    out_sig     <= in_sig;
                    out_data    <= W'(total >>> LOGF);
                end else begin
                    acc[in_sig] <= total;
                    cnt[in_sig] <= cnt[in_sig] + 1'b1;
                end
            end
        end
    end

    AST_DECIM_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R4

    AST_DECIM_SAME_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sig == $past(in_sig)); // R4
endmodule

// File: rtl/avg_decim_front.sv
// Top of the redundant-channel averaging decimator. The chain is: copy
// combiner, divide by copy count, first boxcar decimator, second boxcar
// decimator. The window tracker watches the raw sum. Signals travel
// serially, so one adder per stage serves all of them.
module avg_decim_front
    import avg_decim_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W,
    parameter int NSIG  = DEF_NSIG,
    parameter int NCOPY = DEF_NCOPY,
    parameter int DEC1  = DEF_DEC1,
    parameter int DEC2  = DEF_DEC2,
    localparam int SIG_W = $clog2(NSIG),
    localparam int SUM_W = SMP_W + $clog2(NCOPY),
    localparam int SHIFT = $clog2(NCOPY)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    smp_sof,
    input  logic [SMP_W-1:0]        smp_data,
    input  logic                    win_clear,
    output logic                    out_valid,
    output logic [SIG_W-1:0]        out_sig,
    output logic [SMP_W-1:0]        out_data,
    output logic [NSIG*SUM_W-1:0]   win_min,
    output logic [NSIG*SUM_W-1:0]   win_max,
    output logic [NSIG-1:0]         win_sat
);
    logic                    sum_valid;
    logic [SIG_W-1:0]        sum_sig;
    logic signed [SUM_W-1:0] sum_data;
    logic signed [SMP_W-1:0] avg;
    logic                    mid_valid;
    logic [SIG_W-1:0]        mid_sig;
    logic signed [SMP_W-1:0] mid_data;
    logic signed [SMP_W-1:0] fin_data;

    copy_combiner #(.SMP_W(SMP_W), .NSIG(NSIG), .NCOPY(NCOPY)) u_comb (
        .clk(clk), .rst_n(rst_n),
        .in_valid(smp_valid), .in_sof(smp_sof), .in_data($signed(smp_data)),
        .sum_valid(sum_valid), .sum_sig(sum_sig), .sum_data(sum_data)
    );

    window_tracker #(.SMP_W(SMP_W), .NSIG(NSIG), .NCOPY(NCOPY)) u_win (
        .clk(clk), .rst_n(rst_n),
        .sum_valid(sum_valid), .sum_sig(sum_sig), .sum_data(sum_data),
        .clear(win_clear),
        .min_flat(win_min), .max_flat(win_max), .sat(win_sat)
    );

    // Scale the sum back to single-copy units by an arithmetic shift.
    always_comb avg = SMP_W'(sum_data >>> SHIFT);

    boxcar_decim #(.NSIG(NSIG), .FACTOR(DEC1), .W(SMP_W)) u_dec1 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(sum_valid), .in_sig(sum_sig), .in_data(avg),
        .out_valid(mid_valid), .out_sig(mid_sig), .out_data(mid_data)
    );

    boxcar_decim #(.NSIG(NSIG), .FACTOR(DEC2), .W(SMP_W)) u_dec2 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(mid_valid), .in_sig(mid_sig), .in_data(mid_data),
        .out_valid(out_valid), .out_sig(out_sig), .out_data(fin_data)
    );

    assign out_data = fin_data;

    AST_OUT_SIG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_sig == SIG_W'($past(out_sig) + 1'b1)); // R5
endmodule

// File: tb/tb_avg_decim_front.sv
module tb_avg_decim_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid, smp_sof, win_clear;
    logic [17:0] smp_data;
    logic        out_valid;
    logic [1:0]  out_sig;
    logic [17:0] out_data;
    logic [79:0] win_min, win_max;
    logic [3:0]  win_sat;

    always #2 clk = ~clk;

    avg_decim_front dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sof(smp_sof),
        .smp_data(smp_data), .win_clear(win_clear), .out_valid(out_valid),
        .out_sig(out_sig), .out_data(out_data), .win_min(win_min),
        .win_max(win_max), .win_sat(win_sat)
    );

    int checks = 0, errors = 0, cyc = 0, outs_seen = 0;
    int fv [16];
    int wmin [4], wmax [4];
    bit wre [4];
    int s1a [4], s1c [4], s2a [4], s2c [4];
    int exp_sig [$];
    int exp_dat [$];
    bit gaps = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Drive one sample for one cycle, then perhaps an idle gap (R10).
    task automatic put(input int v, input bit sof, input bit clr);
        smp_valid = 1'b1; smp_data = v[17:0]; smp_sof = sof; win_clear = clr;
        @(negedge clk);
        smp_valid = 1'b0; smp_sof = 1'b0; win_clear = 1'b0;
        if (gaps && $urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    endtask

    // Bench model of one complete frame: window, average, two boxcars.
    task automatic model_frame();
        for (int g = 0; g < 4; g++) begin
            int s, a, o1;
            s = fv[g] + fv[g+4] + fv[g+8] + fv[g+12];
            if (wre[g]) begin wmin[g] = s; wmax[g] = s; wre[g] = 1'b0; end
            else begin
                if (s < wmin[g]) wmin[g] = s;
                if (s > wmax[g]) wmax[g] = s;
            end
            a = s >>> 2;
            s1a[g] += a; s1c[g]++;
            if (s1c[g] == 8) begin
                o1 = s1a[g] >>> 3; s1a[g] = 0; s1c[g] = 0;
                s2a[g] += o1; s2c[g]++;
                if (s2c[g] == 4) begin
                    exp_sig.push_back(g); exp_dat.push_back(s2a[g] >>> 2);
                    s2a[g] = 0; s2c[g] = 0;
                end
            end
        end
    endtask

    task automatic send_frame(input bit clr13);
        model_frame();
        for (int i = 0; i < 16; i++) put(fv[i], i == 0, clr13 && i == 13);
    endtask

    task automatic idle_clear();
        repeat (3) @(negedge clk);
        win_clear = 1'b1; @(negedge clk); win_clear = 1'b0;
        for (int g = 0; g < 4; g++) wre[g] = 1'b1;
    endtask

    task automatic check_window(input string req);
        repeat (3) @(negedge clk);
        for (int g = 0; g < 4; g++) begin
            int amin, amax;
            bit es;
            amin = $signed(win_min[g*20 +: 20]);
            amax = $signed(win_max[g*20 +: 20]);
            es = (wmax[g] >= 524284) || (wmin[g] <= -524288);
            chk(amin == wmin[g], {req, " R6 min"}, amin, wmin[g]);
            chk(amax == wmax[g], {req, " R6 max"}, amax, wmax[g]);
            chk(win_sat[g] == es, {req, " R8 sat"}, int'(win_sat[g]), int'(es));
        end
    endtask

    function automatic int rnd_smp();
        case ($urandom_range(0, 7))
            0: return 131071;
            1: return -131072;
            default: return int'($urandom_range(0, 262143)) - 131072;
        endcase
    endfunction

    // Output monitor: compare each decimated beat with the model (R4, R5).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            outs_seen++;
            if (exp_sig.size() == 0) chk(1'b0, "R5 unexpected output", int'(out_sig), -1);
            else begin
                chk(int'(out_sig) == exp_sig[0], "R5 signal order", int'(out_sig), exp_sig[0]);
                chk(int'($signed(out_data)) == exp_dat[0], "R4 R3 decimated value",
                    int'($signed(out_data)), exp_dat[0]);
                void'(exp_sig.pop_front()); void'(exp_dat.pop_front());
            end
        end
    end

    // Watchdog ends a hung run as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd2718);
        rst_n = 1'b0; smp_valid = 1'b0; smp_sof = 1'b0; smp_data = '0; win_clear = 1'b0;
        for (int g = 0; g < 4; g++) begin
            wre[g] = 1'b1; s1a[g] = 0; s1c[g] = 0; s2a[g] = 0; s2c[g] = 0;
        end
        repeat (5) @(negedge clk);
        // R9: reset state at the ports
        chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
        chk(win_min == '0, "R9 win_min", int'(win_min[19:0]), 0);
        chk(win_max == '0, "R9 win_max", int'(win_max[19:0]), 0);
        chk(win_sat == '0, "R9 win_sat", int'(win_sat), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R8: positive full scale in every copy
        for (int i = 0; i < 16; i++) fv[i] = 131071;
        send_frame(1'b0);
        check_window("R2 positive full scale");

        // R7: idle clear, then negative full scale reloads the window
        idle_clear();
        for (int i = 0; i < 16; i++) fv[i] = -131072;
        send_frame(1'b0);
        check_window("R7 R2 negative full scale");

        // R8: after a clear, an ordinary frame drops the flag
        idle_clear();
        for (int i = 0; i < 16; i++) fv[i] = int'($urandom_range(0, 2000)) - 1000;
        send_frame(1'b0);
        check_window("R8 flag low");

        gaps = 1'b1;
        for (int k = 0; k < 125; k++) begin
            if (k == 40) begin
                // R11: truncated frame, no sums expected
                for (int i = 0; i < 7; i++) put(rnd_smp(), i == 0, 1'b0);
            end
            for (int i = 0; i < 16; i++) fv[i] = rnd_smp();
            if (k == 60) begin
                // R7: clear coincident with signal 0's sum
                gaps = 1'b0;
                for (int g = 0; g < 4; g++) wre[g] = 1'b1;
                send_frame(1'b1);
                check_window("R7 coincident clear");
                gaps = 1'b1;
            end else begin
                send_frame(1'b0);
            end
        end
        gaps = 1'b0;
        repeat (20) @(negedge clk);
        check_window("R1 R6 random frames");
        chk(exp_sig.size() == 0, "R5 R11 pending outputs", exp_sig.size(), 0);
        chk(outs_seen == 16, "R5 R1 output count", outs_seen, 16);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule